// File: doc/BRIEF.md
# Rader Length-7 Real DFT Engine

This block computes the seven-point discrete Fourier transform of real, signed fixed-point samples. It maps every nonzero time and frequency index through powers of the primitive root 3 modulo 7. This turns the six nonzero bins into a six-point cyclic convolution. The convolution is evaluated by a ring of six transposed-form taps. Each tap adds a constant product to the value held by its neighbour and stores the result. All constant products come from one shared block of six shift-and-add multipliers, one for each distinct cosine and sine magnitude, so there is no general multiplier. The zero-frequency bin is the plain sum of the seven samples and has its own accumulator.

A frame is seven samples on a valid/ready input stream. The first accepted sample of a frame is x[0], and the other six follow in generator order. When the seventh sample is taken, the engine stops accepting input (`in_ready` low) and presents the seven bins on a valid/ready output stream. Each bin carries a tag that gives its frequency index. Data enters in one accepted beat per `in_valid && in_ready` cycle, and the source may insert idle cycles. The output holds its value while the sink withholds `out_ready`. The input reopens in the cycle after the last bin is accepted. Internal sums are kept at full width. Each output is rounded once, half up, to the output width.

Top module: `rader7_dft`

## Requirements
- R1: After reset, and after a reset applied in the middle of a frame, `in_ready` is 1 and `out_valid` is 0, and the partial frame is discarded.
- R2: A frame consists of seven accepted samples taken in the order x[0], x[1], x[3], x[2], x[6], x[4], x[5].
- R3: `in_ready` and `out_valid` are never high together. A sample offered while `in_ready` is low is not taken and does not change any result.
- R4: The first bin of a frame has tag 0 and carries the exact sum of the seven samples, with the imaginary part 0.
- R5: For tag k in 1..6, `out_re` is within 2 LSB of sum x[n]·cos(2πkn/7) and `out_im` is within 2 LSB of −sum x[n]·sin(2πkn/7), both at the input scale.
- R6: The output tags (3-bit unsigned frequency index) follow the order 0, 5, 4, 6, 2, 3, 1 in every frame.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_re`, `out_im` and `out_bin` stay unchanged.
- R8: In the cycle after the bin with tag 1 is accepted, `in_ready` is 1 and `out_valid` is 0. The next frame's results do not depend on earlier frames.
- R9: Idle cycles between accepted input samples do not change the results.
- R10: Full-scale frames of either sign (all samples −2^(IN_W−1), or all 2^(IN_W−1)−1) give R4 and R5 results without wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Engine collecting samples |
| in_sample | input | IN_W | Signed input sample |
| out_valid | output | 1 | A bin is presented |
| out_ready | input | 1 | Sink accepts the presented bin |
| out_re | output | IN_W+3 | Signed real part of the bin |
| out_im | output | IN_W+3 | Signed imaginary part of the bin |
| out_bin | output | 3 | Frequency index of the bin |

## Verification
The bench builds the engine with the default IN_W of 12. This gives a 15-bit output, 25-bit constant products and 28-bit tap registers. At this width the full-scale frames of −2048 and +2047 drive the DC sum to the edge of the output range and push the tap registers to their largest magnitude. The impulse, ramp and mixed frames check every cosine and sine constant against a floating-point reference, with a 2-LSB tolerance. Directed runs stall the output, insert input gaps, offer samples during the output phase and reset in the middle of a frame.

// File: rtl/rader7_pkg.sv
package rader7_pkg;
  localparam int N         = 7;
  localparam int NTAP      = N - 1;
  localparam int GEN       = 3;
  localparam int COEF_FRAC = 12;

  typedef enum logic {ST_LOAD, ST_EMIT} phase_e;

  // quantized cos(2*pi*k/7) * 2^12 for k = 1..3
  function automatic int cos_q(input int k);
    case (k)
      1:       return 2554;
      2:       return -911;
      default: return -3690;
    endcase
  endfunction

  // quantized sin(2*pi*k/7) * 2^12 for k = 1..3
  function automatic int sin_q(input int k);
    case (k)
      1:       return 3202;
      2:       return 3993;
      default: return 1777;
    endcase
  endfunction

  function automatic int gen_pow(input int e);
    int r;
    r = 1;
    for (int i = 0; i < e; i++) r = (r * GEN) % N;
    return r;
  endfunction

  // twiddle exponent held by tap j of the shifting ring
  function automatic int tap_exp(input int j);
    return gen_pow((j + NTAP - 1) % NTAP);
  endfunction

  // frequency tag that follows a given tag in the output stream
  function automatic logic [2:0] next_tag(input logic [2:0] t);
    case (t)
      3'd0:    return 3'd5;
      3'd5:    return 3'd4;
      3'd4:    return 3'd6;
      3'd6:    return 3'd2;
      3'd2:    return 3'd3;
      default: return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/rader7_const_mul.sv
module rader7_const_mul #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 25,
  parameter int COEF  = 1,
  parameter int NB    = 13
) (
  input  logic signed [IN_W-1:0]  x,
  output logic signed [OUT_W-1:0] y
);
  localparam int MAG = (COEF < 0) ? -COEF : COEF;
  localparam bit NEG = (COEF < 0);

  logic signed [OUT_W-1:0] xe;
  logic signed [OUT_W-1:0] chain [NB+1];

  assign xe       = {{(OUT_W-IN_W){x[IN_W-1]}}, x};
  assign chain[0] = '0;

  for (genvar b = 0; b < NB; b++) begin : g_bit
    if (((MAG >> b) & 1) == 1) begin : g_add
      assign chain[b+1] = chain[b] + (xe <<< b);
    end else begin : g_pass
      assign chain[b+1] = chain[b];
    end
  end

  assign y = NEG ? -chain[NB] : chain[NB];
endmodule

// File: rtl/rader7_mcm.sv
module rader7_mcm
  import rader7_pkg::*;
#(
  parameter int IN_W = 12,
  parameter int PW   = IN_W + COEF_FRAC + 1
) (
  input  logic signed [IN_W-1:0] x,
  output logic signed [PW-1:0]   pc [3],
  output logic signed [PW-1:0]   ps [3]
);
  for (genvar k = 1; k <= 3; k++) begin : g_const
    rader7_const_mul #(
      .IN_W (IN_W), .OUT_W(PW), .COEF(cos_q(k)), .NB(COEF_FRAC + 1)
    ) u_cos (
      .x(x), .y(pc[k-1])
    );
    rader7_const_mul #(
      .IN_W (IN_W), .OUT_W(PW), .COEF(sin_q(k)), .NB(COEF_FRAC + 1)
    ) u_sin (
      .x(x), .y(ps[k-1])
    );
  end
endmodule

// File: rtl/rader7_ring.sv
module rader7_ring
  import rader7_pkg::*;
#(
  parameter int PW = 25,
  parameter int AW = PW + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 step,
  input  logic signed [PW-1:0] pc [3],
  input  logic signed [PW-1:0] ps [3],
  output logic signed [AW-1:0] acc_re [NTAP],
  output logic signed [AW-1:0] acc_im [NTAP]
);
  for (genvar j = 0; j < NTAP; j++) begin : g_tap
    localparam int E    = tap_exp(j);
    localparam int F    = (E <= 3) ? E : N - E;
    localparam bit NEGS = (E <= 3);
    localparam int PRV  = (j + NTAP - 1) % NTAP;

    logic signed [AW-1:0] c_ext, s_ext, t_re, t_im;

    assign c_ext = {{(AW-PW){pc[F-1][PW-1]}}, pc[F-1]};
    assign s_ext = {{(AW-PW){ps[F-1][PW-1]}}, ps[F-1]};
    assign t_re  = c_ext;
    assign t_im  = NEGS ? -s_ext : s_ext;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_re[j] <= '0;
        acc_im[j] <= '0;
      end else if (clr) begin
        acc_re[j] <= '0;
        acc_im[j] <= '0;
      end else if (step) begin
        acc_re[j] <= acc_re[PRV] + t_re;
        acc_im[j] <= acc_im[PRV] + t_im;
      end
    end
  end

  // R2
  clr_step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr && step));
endmodule

// File: rtl/rader7_dft.sv
module rader7_dft
  import rader7_pkg::*;
#(
  parameter  int IN_W  = 12,
  localparam int OUT_W = IN_W + 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [IN_W-1:0]  in_sample,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_re,
  output logic signed [OUT_W-1:0] out_im,
  output logic [2:0]              out_bin
);
  localparam int PW = IN_W + COEF_FRAC + 1;
  localparam int AW = PW + 3;
  localparam logic signed [AW-1:0] HALF = AW'(1) << (COEF_FRAC - 1);

  phase_e                 phase;
  logic [2:0]             cnt;
  logic signed [IN_W-1:0] x0;
  logic signed [OUT_W-1:0] dc;
  logic                   take, give;

  logic signed [PW-1:0] pc [3];
  logic signed [PW-1:0] ps [3];
  logic signed [AW-1:0] acc_re [NTAP];
  logic signed [AW-1:0] acc_im [NTAP];

  assign in_ready  = (phase == ST_LOAD);
  assign out_valid = (phase == ST_EMIT);
  assign take      = in_valid && in_ready;
  assign give      = out_valid && out_ready;

  rader7_mcm #(.IN_W(IN_W), .PW(PW)) u_mcm (
    .x(in_sample), .pc(pc), .ps(ps)
  );

  rader7_ring #(.PW(PW), .AW(AW)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .clr (take && (cnt == 3'd0)),
    .step(take && (cnt != 3'd0)),
    .pc(pc), .ps(ps), .acc_re(acc_re), .acc_im(acc_im)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= ST_LOAD;
      cnt   <= '0;
      x0    <= '0;
      dc    <= '0;
    end else if (phase == ST_LOAD) begin
      if (take) begin
        if (cnt == 3'd0) begin
          x0 <= in_sample;
          dc <= {{3{in_sample[IN_W-1]}}, in_sample};
        end else begin
          dc <= dc + {{3{in_sample[IN_W-1]}}, in_sample};
        end
        if (cnt == 3'd6) begin
          phase <= ST_EMIT;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 3'd1;
        end
      end
    end else if (give) begin
      if (cnt == 3'd6) begin
        phase <= ST_LOAD;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 3'd1;
      end
    end
  end

  // output selection: emit slot 1..6 reads ring tap 5..0
  logic [2:0]           slot;
  logic signed [AW-1:0] sel_re, sel_im, x0_sh, v_re, v_im;
  logic                 unused_low;

  assign slot   = (cnt == 3'd0) ? 3'd0 : 3'd6 - cnt;
  assign sel_re = acc_re[slot];
  assign sel_im = acc_im[slot];
  assign x0_sh  = {{(AW-IN_W-COEF_FRAC){x0[IN_W-1]}}, x0, {COEF_FRAC{1'b0}}};
  assign v_re   = sel_re + x0_sh + HALF;
  assign v_im   = sel_im + HALF;
  assign unused_low = ^{v_re[COEF_FRAC-1:0], v_re[AW-1], v_im[COEF_FRAC-1:0], v_im[AW-1]};

  always_comb begin
    if (cnt == 3'd0) begin
      out_re  = dc;
      out_im  = '0;
      out_bin = 3'd0;
    end else begin
      out_re  = v_re[COEF_FRAC +: OUT_W];
      out_im  = v_im[COEF_FRAC +: OUT_W];
      out_bin = 3'(gen_pow(int'(slot)));
    end
  end

  // R3
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R7
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_re) &&
                                   $stable(out_im) && $stable(out_bin)));

  // R6
  tag_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (give && out_bin != 3'd1) |=> (out_valid && out_bin == next_tag($past(out_bin))));

  // R4
  dc_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_bin == 3'd0));

  // R8
  reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (give && out_bin == 3'd1) |=> (in_ready && !out_valid));
endmodule

// File: tb/rader7_dft_test.sv
module rader7_dft_test;
  localparam int  CLK_P = 10;
  localparam int  IN_W  = 12;
  localparam int  OUT_W = IN_W + 3;
  localparam int  NF    = 7;
  localparam real PI    = 3.14159265358979;
  localparam real TOL   = 2.0;

  // frames in natural order x[0..6]
  localparam logic signed [IN_W-1:0] VEC [NF][7] = '{
    '{1000, 0, 0, 0, 0, 0, 0},
    '{0, 1000, 0, 0, 0, 0, 0},
    '{100, 200, 300, 400, 500, 600, 700},
    '{2047, 2047, 2047, 2047, 2047, 2047, 2047},
    '{-2048, -2048, -2048, -2048, -2048, -2048, -2048},
    '{2047, -2048, 1500, -7, 0, 900, -1234},
    '{5, -3, 77, -1000, 2000, -500, 33}
  };
  localparam int ORDER_IN  [7] = '{0, 1, 3, 2, 6, 4, 5};
  localparam int ORDER_OUT [7] = '{0, 5, 4, 6, 2, 3, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [IN_W-1:0] in_sample = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic signed [OUT_W-1:0] out_re, out_im;
  logic [2:0] out_bin;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  rader7_dft #(.IN_W(IN_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_sample(in_sample),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im), .out_bin(out_bin)
  );

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_near(input string req, input string what, input int act, input real exp);
    real d;
    n_cmp++;
    d = real'(act) - exp;
    if (d < 0.0) d = -d;
    if (d > TOL) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %f", req, what, act, exp);
    end
  endtask

  function automatic real ref_re(input int f, input int k);
    real s = 0.0;
    for (int n = 0; n < 7; n++) s += real'(VEC[f][n]) * $cos(2.0 * PI * k * n / 7.0);
    return s;
  endfunction

  function automatic real ref_im(input int f, input int k);
    real s = 0.0;
    for (int n = 0; n < 7; n++) s -= real'(VEC[f][n]) * $sin(2.0 * PI * k * n / 7.0);
    return s;
  endfunction

  // starts and ends at a falling edge
  task automatic send_one(input logic signed [IN_W-1:0] v, input int gap);
    repeat (gap) @(negedge clk);
    in_valid  = 1'b1;
    in_sample = v;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // R2: generator order of the six nonzero indices after x[0]
  task automatic send_frame(input int f, input int gap);
    for (int i = 0; i < 7; i++) send_one(VEC[f][ORDER_IN[i]], (i % 2 == 1) ? gap : 0);
  endtask

  task automatic recv_frame(input int f, input int stall, input string req);
    int re, im, tag, k;
    for (int i = 0; i < 7; i++) begin
      k = ORDER_OUT[i];
      out_ready = 1'b0;
      while (!out_valid) @(negedge clk);
      if (stall > 0 && i == 2) begin
        re = out_re; im = out_im; tag = out_bin;
        repeat (stall) begin
          @(negedge clk);
          chk_eq("R7", "valid under stall", int'(out_valid), 1);
          chk_eq("R7", "re under stall", int'(out_re), re);
          chk_eq("R7", "im under stall", int'(out_im), im);
          chk_eq("R7", "tag under stall", int'(out_bin), tag);
        end
      end
      re = out_re; im = out_im; tag = out_bin;
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      chk_eq("R6", "bin tag", tag, k);
      if (i == 0) begin
        chk_near(req, "dc real", re, ref_re(f, 0));
        chk_eq("R4", "dc real exact", re, int'(ref_re(f, 0)));
        chk_eq("R4", "dc imag", im, 0);
      end else begin
        chk_near(req, $sformatf("bin %0d real", k), re, ref_re(f, k));
        chk_near(req, $sformatf("bin %0d imag", k), im, ref_im(f, k));
      end
    end
    chk_eq("R8", "in_ready after frame", int'(in_ready), 1);
    chk_eq("R8", "out_valid after frame", int'(out_valid), 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R8 watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk_eq("R1", "in_ready in reset", int'(in_ready), 1);
    chk_eq("R1", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1", "in_ready after reset", int'(in_ready), 1);
    chk_eq("R1", "out_valid after reset", int'(out_valid), 0);

    // table walk: R5 general frames, R10 full scale, R9 gaps, R7 stall
    for (int f = 0; f < NF; f++) begin
      string req;
      req = (f == 3 || f == 4) ? "R10" : ((f == 5) ? "R9" : "R5");
      send_frame(f, (f == 5) ? 2 : 0);
      recv_frame(f, (f == 2 || f == 6) ? 3 : 0, req);
    end

    // R3: samples offered during the output phase are not taken
    send_frame(5, 0);
    in_valid  = 1'b1;
    in_sample = -12'sd1;
    repeat (3) begin
      chk_eq("R3", "in_ready while emitting", int'(in_ready), 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    recv_frame(5, 0, "R3");
    send_frame(6, 0);
    recv_frame(6, 0, "R3");

    // R1: reset in the middle of a frame discards the partial frame
    send_one(12'sd777, 0);
    send_one(-12'sd555, 0);
    send_one(12'sd333, 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk_eq("R1", "in_ready in mid-frame reset", int'(in_ready), 1);
    chk_eq("R1", "out_valid in mid-frame reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    send_frame(1, 0);
    recv_frame(1, 0, "R1");

    finish_run();
  end
endmodule